// File: doc/BRIEF.md
# LBA48 Command Register File

This block models, on the device side, the byte-wide register file through which a host sets up and launches a 48-bit-addressed disk command. The host reaches it through a small port: a 3-bit offset, a read strobe, a write strobe, a write byte and a registered read byte. The block stores a features byte, a device-select byte, a sector count and a logical block address. It returns a status byte and an error byte, most of whose bits come from the device core.

The count register and the three address registers each keep a two-entry history. Every write pushes the byte already held into a "previous" slot and stores the new byte as "current". A host that writes each of these offsets twice therefore builds a 16-bit count and a 48-bit address: the first pass supplies the upper halves and the second pass supplies the lower halves.

A write to the command offset launches the command. The block checks three things: the device is idle, the addressed device exists, and the code is one it supports. If all hold, it presents the code, the assembled count and address, the features byte and the device bit on a one-cycle issue output, and it raises busy until the core signals completion. If the code is unsupported, the block does not issue the command and instead reports an abort.

Top module: `lba48_taskfile`

## Requirements
- R1: After synchronous reset the read byte is 0x00, the issue strobe is low, and a status read (offset 7) with all core status inputs at zero returns 0x00.
- R2: Each write to offsets 2, 3, 4 or 5 moves that register's current byte into its previous slot and stores the written byte as current. A read of such an offset returns the current byte.
- R3: On issue, the count is {previous, current} of offset 2. The address is, from bit 47 down to bit 0, previous of offsets 5, 4, 3, then current of offsets 5, 4, 3.
- R4: A command write (offset 7) of code 0x25 or 0x35, accepted while idle and addressed to a present device, raises `cmd_valid` for exactly one cycle, starting the cycle after the write. It carries the code, the count, the address, the features byte (last value written to offset 1) and the device bit.
- R5: An accepted command sets status bit 7 (busy). Busy stays set until a cycle in which `core_done` is high.
- R6: A command write made while busy is ignored: it causes no issue, and the status and error bytes do not change.
- R7: A command write with any other code, accepted while idle and addressed to a present device, is not issued and leaves busy clear. It sets status bit 0 and error bit 2 (0x04). These stay set until the next issued command.
- R8: Bit 4 of the device-select byte (offset 6) picks device 1 when set and device 0 when clear. A command write to a device whose `dev_present` bit is 0 has no effect: no issue, no busy, no abort.
- R9: The status byte is {busy, core_status[6:1], core_status[0] OR abort}. The error byte is core_error with bit 2 ORed with abort.
- R10: `rd_data` updates one cycle after a read strobe and holds while no read strobe is given. Offset 0 reads 0x00, and offset 6 reads back the device-select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| dev_present | input | 2 | Per-device presence flags |
| core_status | input | 8 | Status bits from the device core (bit 7 unused) |
| core_error | input | 8 | Error bits from the device core |
| core_done | input | 1 | Command completion pulse from the core |
| cmd_valid | output | 1 | One-cycle command issue strobe |
| cmd_code | output | 8 | Issued command code |
| cmd_count | output | 16 | Issued sector count |
| cmd_lba | output | 48 | Issued block address |
| cmd_dev | output | 1 | Issued device bit |
| cmd_feature | output | 8 | Issued features byte |

## Verification
Assertions check on every cycle that an issue lasts a single cycle and never arises from a busy state. They also check that every issued code is in the supported set, that an issue coincides with busy set and abort clear, that completion clears busy, and that each history register shifts its current byte into its previous slot on a write. Only the bench scenarios can show that the bytes assemble into the right count and address layout. The same holds for the rules that make an absent-device command inert and that clear the abort flag on the next issued command, and for the way the status and error bytes merge the core's bits with the block's own flags.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_FEAT   = 3'd1;
  localparam logic [2:0] OFS_COUNT  = 3'd2;
  localparam logic [2:0] OFS_DEVSEL = 3'd6;
  localparam logic [2:0] OFS_CMD    = 3'd7;

  localparam logic [7:0] CODE_RD_EXT = 8'h25;
  localparam logic [7:0] CODE_WR_EXT = 8'h35;

  localparam int ST_BUSY_BIT  = 7;
  localparam int ST_ERR_BIT   = 0;
  localparam int ER_ABORT_BIT = 2;

  function automatic logic code_supported(input logic [7:0] code);
    return (code == CODE_RD_EXT) || (code == CODE_WR_EXT);
  endfunction
endpackage

// File: rtl/tf_shadow_byte.sv
module tf_shadow_byte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] prev_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (wr_hit) begin
      prev_q <= cur_q;
      cur_q  <= wr_data;
    end
  end

  // R2: a write pushes the held byte into the history slot
  p_shift_history_r2: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (prev_q == $past(cur_q)) && (cur_q == $past(wr_data)));
endmodule

// File: rtl/tf_cmd_ctrl.sv
module tf_cmd_ctrl
  import tf_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int CNT_W   = 16,
  parameter int LBA_W   = 48,
  localparam int DEV_IW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] code_in,
  input  logic [DEV_IW-1:0] dev_sel,
  input  logic [NUM_DEV-1:0] dev_present,
  input  logic              core_done,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [LBA_W-1:0]  lba_in,
  input  logic [BYTE_W-1:0] feat_in,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_code,
  output logic [CNT_W-1:0]  cmd_count,
  output logic [LBA_W-1:0]  cmd_lba,
  output logic [DEV_IW-1:0] cmd_dev,
  output logic [BYTE_W-1:0] cmd_feature,
  output logic              busy_q,
  output logic              abort_q
);
  logic dev_ok, accept, launch;

  always_comb begin
    dev_ok = dev_present[dev_sel];
    accept = cmd_wr && !busy_q && dev_ok;
    launch = accept && code_supported(code_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid   <= 1'b0;
      cmd_code    <= '0;
      cmd_count   <= '0;
      cmd_lba     <= '0;
      cmd_dev     <= '0;
      cmd_feature <= '0;
      busy_q      <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      cmd_valid <= launch;
      if (busy_q && core_done) busy_q <= 1'b0;
      if (launch) begin
        cmd_code    <= code_in;
        cmd_count   <= count_in;
        cmd_lba     <= lba_in;
        cmd_dev     <= dev_sel;
        cmd_feature <= feat_in;
        busy_q      <= 1'b1;
        abort_q     <= 1'b0;
      end else if (accept) begin
        abort_q <= 1'b1;
      end
    end
  end

  // R4: issue strobe lasts one cycle
  p_issue_single_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R4: only supported codes leave the block
  p_issue_code_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> code_supported(cmd_code));
  // R5: an issued command is accompanied by busy
  p_issue_busy_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy_q);
  // R5: completion releases busy
  p_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && core_done) |=> !busy_q);
  // R6: no issue can come from a busy state
  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !$past(busy_q));
  // R7: abort and issue are exclusive
  p_abort_excl_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !abort_q);
endmodule

// File: rtl/tf_read_mux.sv
module tf_read_mux
  import tf_pkg::*;
#(
  parameter int NUM_SHADOW = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en,
  input  logic [2:0]                        addr,
  input  logic [NUM_SHADOW-1:0][BYTE_W-1:0] cur_bytes,
  input  logic [BYTE_W-1:0]                 devsel_q,
  input  logic                              busy,
  input  logic                              abort,
  input  logic [BYTE_W-1:0]                 core_status,
  input  logic [BYTE_W-1:0]                 core_error,
  output logic [BYTE_W-1:0]                 rd_data
);
  logic [BYTE_W-1:0] status_b, error_b, sel_b;

  always_comb begin
    status_b = core_status;
    status_b[ST_BUSY_BIT] = busy;
    status_b[ST_ERR_BIT]  = core_status[ST_ERR_BIT] | abort;
    error_b = core_error;
    error_b[ER_ABORT_BIT] = core_error[ER_ABORT_BIT] | abort;
    sel_b = '0;
    if (addr == OFS_FEAT) sel_b = error_b;
    else if (addr == OFS_DEVSEL) sel_b = devsel_q;
    else if (addr == OFS_CMD) sel_b = status_b;
    else if (addr >= OFS_COUNT && addr < OFS_COUNT + 3'(NUM_SHADOW))
      sel_b = cur_bytes[addr - OFS_COUNT];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= sel_b;
  end

  // R10: read byte holds without a strobe
  p_read_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/lba48_taskfile.sv
module lba48_taskfile
  import tf_pkg::*;
#(
  parameter int NUM_DEV     = 2,
  parameter int DEV_SEL_BIT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   addr,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic [7:0]   wr_data,
  output logic [7:0]   rd_data,
  input  logic [1:0]   dev_present,
  input  logic [7:0]   core_status,
  input  logic [7:0]   core_error,
  input  logic         core_done,
  output logic         cmd_valid,
  output logic [7:0]   cmd_code,
  output logic [15:0]  cmd_count,
  output logic [47:0]  cmd_lba,
  output logic         cmd_dev,
  output logic [7:0]   cmd_feature
);
  localparam int NUM_SHADOW = 4;
  localparam int LBA_BYTES  = NUM_SHADOW - 1;
  localparam int CNT_W      = 2 * BYTE_W;
  localparam int LBA_W      = 2 * LBA_BYTES * BYTE_W;

  logic [NUM_SHADOW-1:0][BYTE_W-1:0] cur_b, prev_b;
  logic [BYTE_W-1:0] feat_q, devsel_q;
  logic [CNT_W-1:0]  count_w;
  logic [LBA_W-1:0]  lba_w;
  logic busy, abort;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SHADOW; gi++) begin : g_shadow
      tf_shadow_byte #(.W(BYTE_W)) u_sh (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_en && (addr == OFS_COUNT + 3'(gi))),
        .wr_data (wr_data),
        .cur_q   (cur_b[gi]),
        .prev_q  (prev_b[gi])
      );
    end
    for (gi = 0; gi < LBA_BYTES; gi++) begin : g_lba
      assign lba_w[gi*BYTE_W +: BYTE_W]               = cur_b[gi+1];
      assign lba_w[(gi+LBA_BYTES)*BYTE_W +: BYTE_W]   = prev_b[gi+1];
    end
  endgenerate

  assign count_w = {prev_b[0], cur_b[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      feat_q   <= '0;
      devsel_q <= '0;
    end else if (wr_en) begin
      if (addr == OFS_FEAT)   feat_q   <= wr_data;
      if (addr == OFS_DEVSEL) devsel_q <= wr_data;
    end
  end

  tf_cmd_ctrl #(
    .NUM_DEV (NUM_DEV),
    .CNT_W   (CNT_W),
    .LBA_W   (LBA_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (wr_en && (addr == OFS_CMD)),
    .code_in     (wr_data),
    .dev_sel     (devsel_q[DEV_SEL_BIT]),
    .dev_present (dev_present),
    .core_done   (core_done),
    .count_in    (count_w),
    .lba_in      (lba_w),
    .feat_in     (feat_q),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_count   (cmd_count),
    .cmd_lba     (cmd_lba),
    .cmd_dev     (cmd_dev),
    .cmd_feature (cmd_feature),
    .busy_q      (busy),
    .abort_q     (abort)
  );

  tf_read_mux #(.NUM_SHADOW(NUM_SHADOW)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .addr        (addr),
    .cur_bytes   (cur_b),
    .devsel_q    (devsel_q),
    .busy        (busy),
    .abort       (abort),
    .core_status (core_status),
    .core_error  (core_error),
    .rd_data     (rd_data)
  );
endmodule

// File: tb/lba48_taskfile_test.sv
module lba48_taskfile_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] dev_present = 2'b11;
  logic [7:0] core_status = '0, core_error = '0;
  logic core_done = 1'b0;
  logic cmd_valid;
  logic [7:0] cmd_code, cmd_feature;
  logic [15:0] cmd_count;
  logic [47:0] cmd_lba;
  logic cmd_dev;

  int tests = 0, fails = 0;
  logic [80:0] exp_q[$];
  logic [7:0] rb;

  always #5 clk = ~clk;

  lba48_taskfile uut (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .dev_present(dev_present),
    .core_status(core_status), .core_error(core_error), .core_done(core_done),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_count(cmd_count),
    .cmd_lba(cmd_lba), .cmd_dev(cmd_dev), .cmd_feature(cmd_feature)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic issue(input logic [7:0] code, input logic [15:0] cnt, input logic [47:0] lba,
                       input logic dev, input logic [7:0] feat);
    exp_q.push_back({code, cnt, lba, dev, feat});
    wr(3'd7, code);
  endtask

  task automatic done_pulse();
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
  endtask

  // Scoreboard monitor: R3, R4, R8 fields; R6 unexpected issue
  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected issue", {56'd0, cmd_code}, 64'd0);
      end else begin
        logic [80:0] e;
        e = exp_q.pop_front();
        check(cmd_code == e[80:73], "R4 code", cmd_code, e[80:73]);
        check(cmd_count == e[72:57], "R3 count", cmd_count, e[72:57]);
        check(cmd_lba == e[56:9], "R3 lba", cmd_lba, e[56:9]);
        check(cmd_dev == e[8], "R8 device bit", cmd_dev, e[8]);
        check(cmd_feature == e[7:0], "R4 feature", cmd_feature, e[7:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data == 8'h00, "R1 rd_data reset", rd_data, 0);
    check(cmd_valid == 1'b0, "R1 cmd_valid reset", cmd_valid, 0);
    rd(3'd7, rb); check(rb == 8'h00, "R1 status reset", rb, 0);

    // R2 history and readback
    wr(3'd2, 8'h12); wr(3'd2, 8'h34);
    rd(3'd2, rb); check(rb == 8'h34, "R2 count current", rb, 8'h34);
    wr(3'd3, 8'hA1); wr(3'd3, 8'hB1);
    wr(3'd4, 8'hA2); wr(3'd4, 8'hB2);
    wr(3'd5, 8'hA3); wr(3'd5, 8'hB3);
    rd(3'd4, rb); check(rb == 8'hB2, "R2 lba current", rb, 8'hB2);
    wr(3'd1, 8'h5A); wr(3'd6, 8'h00);
    issue(8'h25, 16'h1234, 48'hA3A2A1B3B2B1, 1'b0, 8'h5A);
    rd(3'd7, rb); check(rb == 8'h80, "R5 busy set", rb, 8'h80);
    core_status = 8'h40;
    rd(3'd7, rb); check(rb == 8'hC0, "R9 status merge", rb, 8'hC0);

    // R6 command while busy
    wr(3'd7, 8'h35);
    rd(3'd7, rb); check(rb == 8'hC0, "R6 status unchanged", rb, 8'hC0);
    rd(3'd1, rb); check(rb == 8'h00, "R6 error unchanged", rb, 0);
    done_pulse();
    rd(3'd7, rb); check(rb == 8'h40, "R5 done clears busy", rb, 8'h40);

    // R8 slave device
    wr(3'd2, 8'h00); wr(3'd2, 8'h08);
    wr(3'd3, 8'h01); wr(3'd3, 8'h02);
    wr(3'd4, 8'h03); wr(3'd4, 8'h04);
    wr(3'd5, 8'h05); wr(3'd5, 8'h06);
    wr(3'd6, 8'h10);
    issue(8'h35, 16'h0008, 48'h050301060402, 1'b1, 8'h5A);
    done_pulse();

    // R7 unsupported code
    wr(3'd7, 8'hEC);
    rd(3'd7, rb); check(rb == 8'h41, "R7 abort status", rb, 8'h41);
    rd(3'd1, rb); check(rb == 8'h04, "R7 abort error", rb, 8'h04);
    core_error = 8'h10;
    rd(3'd1, rb); check(rb == 8'h14, "R9 error merge", rb, 8'h14);
    core_error = 8'h00;

    // R8 absent device
    dev_present = 2'b01;
    wr(3'd7, 8'h25);
    rd(3'd7, rb); check(rb == 8'h41, "R8 absent no effect", rb, 8'h41);
    rd(3'd6, rb); check(rb == 8'h10, "R10 devsel readback", rb, 8'h10);

    // R7 cleared by next issue
    wr(3'd6, 8'h00);
    issue(8'h25, 16'h0008, 48'h050301060402, 1'b0, 8'h5A);
    rd(3'd7, rb); check(rb == 8'hC0, "R7 abort cleared", rb, 8'hC0);
    done_pulse();

    // R10 offset 0 and hold
    rd(3'd0, rb); check(rb == 8'h00, "R10 offset 0", rb, 0);
    rd(3'd3, rb);
    @(negedge clk); addr = 3'd7;
    @(negedge clk);
    check(rd_data == 8'h02, "R10 hold", rd_data, 8'h02);

    // R2 third write drops oldest
    wr(3'd2, 8'h01); wr(3'd2, 8'h02); wr(3'd2, 8'h03);
    issue(8'h35, 16'h0203, 48'h050301060402, 1'b0, 8'h5A);
    done_pulse();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all issued", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule